// File: doc/BRIEF.md
# Self-Testing Two-Level Logic Array

This block is a parameterized sum-of-products logic array: an AND plane builds product terms from the true and inverted copies of its inputs, and an OR plane combines those terms into the outputs. Both connection matrices are elaboration-time parameters. The default instance has four inputs, two outputs and six product terms.

The array carries hardware that makes it testable with one fixed set of patterns, whatever function it holds. A serially loaded column-enable register can switch off each product column on its own. Two force pins drive every true-input line or every inverted-input line high. One extra product column is wired so that every AND-plane row has an odd number of connections. One extra OR row is wired so that every product column has an odd number of OR connections. Two parity outputs expose the XOR of all product lines and the XOR of all OR rows. Single faults then show up as a parity flip, and a complete single-fault test takes 3k + 2n patterns, where k is the column count including the parity column and n is the input count. For normal operation both force pins are held low and every enable bit is 1, which is also the reset value.

There is no streaming interface and no handshake. Data, force pins and the enable register feed the outputs combinationally. Only the enable register is clocked.

Top module: `pla_testable`

## Requirements
- R1: With both force pins low and every enable bit 1, each output `y[o]` is the OR, over the product terms connected to it, of the AND of that term's chosen true or inverted inputs. In the default personality, with x1..x4 being `data_in[0]`..`data_in[3]`, y1 (`y[0]`) = x1x2 + x1'x3 + x2x4' and y2 (`y[1]`) = x1x2 + x3x4 + x2'x3' + x1x3'x4.
- R2: A product column whose enable bit is 0 drives 0 onto its product line. With all enable bits 0, every output and both parity outputs are 0.
- R3: While `sel_shift` is high, the enable register moves one place per rising clock edge. `sel_in` enters column 1 (bit 0) and each bit i takes the old bit i-1. While `sel_shift` is low, the register holds its value.
- R4: The active-low asynchronous reset sets every enable bit to 1, which puts the array in normal mode.
- R5: `force_true` drives every true-input line to 1 while the inverted-input lines keep following the inputs.
- R6: `force_comp` drives every inverted-input line to 1 while the true-input lines keep following the inputs.
- R7: The parity column (the top enable bit, column k) connects to a line exactly when that line has an even number of connections among the ordinary columns. It feeds no ordinary output. `par_and` is the XOR of all k product lines.
- R8: The parity OR row connects to a column exactly when that column has an even number of connections to the ordinary outputs. It always connects to the parity column. `par_or` is the XOR of the ordinary outputs and the parity row. A single added OR connection in the personality flips `par_or` for the affected column.
- R9: Outputs respond in the same cycle to changes of `data_in`, the force pins and the enable register, with no register in that path.
- R10: With both force pins high and exactly one enable bit set, `par_and` and `par_or` are both 1, and `y` shows exactly that column's OR connections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the enable register |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_shift | input | 1 | Shift the enable register by one place this cycle |
| sel_in | input | 1 | Serial bit entering column 1 |
| force_true | input | 1 | Force all true-input lines high |
| force_comp | input | 1 | Force all inverted-input lines high |
| data_in | input | N_IN | Array inputs, bit 0 = x1 |
| y | output | N_OUT | Array outputs, bit 0 = y1 |
| par_and | output | 1 | XOR of all product lines |
| par_or | output | 1 | XOR of all OR rows including the parity row |

## Verification
On every clock, the assertions check how the enable register moves and holds. They also check that a fully disabled array is silent, and that a single enabled column under both forces gives odd parity on both outputs. Only the bench's scenarios can show the actual logic function across all input values, the effect of each force pin alone, the reset value seen through the outputs, and that an injected personality fault is exposed by the parity outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Line-forcing mode, encoded as {force_comp, force_true}.
  typedef enum logic [1:0] {
    FORCE_NONE = 2'b00,
    FORCE_TRUE = 2'b01,
    FORCE_COMP = 2'b10,
    FORCE_BOTH = 2'b11
  } force_e;

  function automatic logic lifts_true(input force_e m);
    return (m == FORCE_TRUE) || (m == FORCE_BOTH);
  endfunction

  function automatic logic lifts_comp(input force_e m);
    return (m == FORCE_COMP) || (m == FORCE_BOTH);
  endfunction

endpackage

// File: rtl/pla_sel_chain.sv
// Serial column-enable register: resets to all ones, shifts toward higher columns.
module pla_sel_chain #(
  parameter int unsigned K = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [K-1:0] sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '1;
    end else if (shift) begin
      sel <= {sel[K-2:0], din};
    end
  end

endmodule

// File: rtl/pla_line_drv.sv
// Builds the true and inverted horizontal lines, with the test overrides applied.
module pla_line_drv
  import pla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] data_in,
  input  force_e       mode,
  output logic [N-1:0] line_t,
  output logic [N-1:0] line_c
);

  logic lift_t;
  logic lift_c;

  always_comb begin
    lift_t = lifts_true(mode);
    lift_c = lifts_comp(mode);
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign line_t[i] = data_in[i] | lift_t;
    assign line_c[i] = ~data_in[i] | lift_c;
  end

endmodule

// File: rtl/pla_and_plane.sv
// One gated AND column per product term; an unconnected line does not constrain the term.
module pla_and_plane #(
  parameter int unsigned N = 4,
  parameter int unsigned K = 7
) (
  input  logic [N-1:0]   line_t,
  input  logic [N-1:0]   line_c,
  input  logic [K*N-1:0] mask_t,
  input  logic [K*N-1:0] mask_c,
  input  logic [K-1:0]   sel,
  output logic [K-1:0]   prod
);

  for (genvar j = 0; j < K; j++) begin : g_col
    logic [N-1:0] ok_t;
    logic [N-1:0] ok_c;
    assign ok_t    = ~mask_t[j*N +: N] | line_t;
    assign ok_c    = ~mask_c[j*N +: N] | line_c;
    assign prod[j] = sel[j] & (&ok_t) & (&ok_c);
  end

endmodule

// File: rtl/pla_or_plane.sv
// OR rows over the product lines; row r uses map bits r*K .. r*K+K-1.
module pla_or_plane #(
  parameter int unsigned K = 7,
  parameter int unsigned R = 3
) (
  input  logic [K-1:0]   prod,
  input  logic [R*K-1:0] map,
  output logic [R-1:0]   row
);

  for (genvar r = 0; r < R; r++) begin : g_row
    assign row[r] = |(map[r*K +: K] & prod);
  end

endmodule

// File: rtl/pla_testable.sv
module pla_testable
  import pla_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_OUT  = 2,
  parameter int unsigned N_TERM = 6,
  // Term j uses true input i when AND_TRUE[j*N_IN+i] is set, inverted input i when AND_COMP[j*N_IN+i] is set.
  parameter logic [N_TERM*N_IN-1:0]  AND_TRUE  = 24'h90C243,
  parameter logic [N_TERM*N_IN-1:0]  AND_COMP  = 24'h460810,
  // Output o takes term j when OR_MAP[o*N_TERM+j] is set.
  parameter logic [N_OUT*N_TERM-1:0] OR_MAP    = 12'hE47,
  // Defect injection: XORed into the personality after the parity wiring is derived.
  parameter logic [N_TERM*N_IN-1:0]  FLIP_TRUE = '0,
  parameter logic [N_TERM*N_IN-1:0]  FLIP_COMP = '0,
  parameter logic [N_OUT*N_TERM-1:0] FLIP_OR   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_shift,
  input  logic             sel_in,
  input  logic             force_true,
  input  logic             force_comp,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] y,
  output logic             par_and,
  output logic             par_or
);

  localparam int unsigned K = N_TERM + 1;  // product columns incl. parity column
  localparam int unsigned R = N_OUT + 1;   // OR rows incl. parity row
  localparam bit HEALTHY = (FLIP_TRUE == '0) && (FLIP_COMP == '0) && (FLIP_OR == '0);

  // Parity-column wiring: bit i (true line i) or N_IN+i (inverted line i) set when the line count is even.
  function automatic logic [2*N_IN-1:0] parity_col();
    logic [2*N_IN-1:0] pc;
    for (int i = 0; i < N_IN; i++) begin
      logic odd_t;
      logic odd_c;
      odd_t = 1'b0;
      odd_c = 1'b0;
      for (int j = 0; j < N_TERM; j++) begin
        odd_t ^= AND_TRUE[j*N_IN+i];
        odd_c ^= AND_COMP[j*N_IN+i];
      end
      pc[i]      = ~odd_t;
      pc[N_IN+i] = ~odd_c;
    end
    return pc;
  endfunction

  // Full OR map with parity column and parity row added.
  function automatic logic [R*K-1:0] full_or_map();
    logic [R*K-1:0] m;
    m = '0;
    for (int j = 0; j < N_TERM; j++) begin
      logic odd;
      odd = 1'b0;
      for (int o = 0; o < N_OUT; o++) begin
        m[o*K+j] = OR_MAP[o*N_TERM+j] ^ FLIP_OR[o*N_TERM+j];
        odd ^= OR_MAP[o*N_TERM+j];
      end
      m[N_OUT*K+j] = ~odd;
    end
    m[N_OUT*K+N_TERM] = 1'b1;
    return m;
  endfunction

  localparam logic [2*N_IN-1:0] PCOL   = parity_col();
  localparam logic [K*N_IN-1:0] MASK_T = {PCOL[N_IN-1:0],      AND_TRUE ^ FLIP_TRUE};
  localparam logic [K*N_IN-1:0] MASK_C = {PCOL[2*N_IN-1:N_IN], AND_COMP ^ FLIP_COMP};
  localparam logic [R*K-1:0]    OMAP   = full_or_map();

  logic [K-1:0]    sel_q;
  logic [N_IN-1:0] line_t;
  logic [N_IN-1:0] line_c;
  logic [K-1:0]    prod;
  logic [R-1:0]    row;
  force_e          mode;

  assign mode = force_e'({force_comp, force_true});

  pla_sel_chain #(.K(K)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (sel_shift),
    .din   (sel_in),
    .sel   (sel_q)
  );

  pla_line_drv #(.N(N_IN)) u_lines (
    .data_in (data_in),
    .mode    (mode),
    .line_t  (line_t),
    .line_c  (line_c)
  );

  pla_and_plane #(.N(N_IN), .K(K)) u_and (
    .line_t (line_t),
    .line_c (line_c),
    .mask_t (MASK_T),
    .mask_c (MASK_C),
    .sel    (sel_q),
    .prod   (prod)
  );

  pla_or_plane #(.K(K), .R(R)) u_or (
    .prod (prod),
    .map  (OMAP),
    .row  (row)
  );

  assign y       = row[N_OUT-1:0];
  assign par_and = ^prod;
  assign par_or  = ^row;

endmodule

// File: rtl/pla_testable_chk.sv
module pla_testable_chk #(
  parameter int unsigned K       = 7,
  parameter int unsigned N_OUT   = 2,
  parameter bit          HEALTHY = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_shift,
  input logic             sel_in,
  input logic             force_true,
  input logic             force_comp,
  input logic [K-1:0]     sel_q,
  input logic [N_OUT-1:0] y,
  input logic             par_and,
  input logic             par_or
);

  // R4: while reset is held, every column is enabled
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r4_reset_all_on: assert (sel_q == '1);
    end
  end

  // R3: no shift request, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_shift |=> $stable(sel_q));

  // R3: serial bit lands in column 1
  a_r3_shift_entry: assert property (@(posedge clk) disable iff (!rst_n)
    sel_shift |=> sel_q[0] == $past(sel_in));

  // R3: other bits move up one column
  a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    sel_shift |=> sel_q[K-1:1] == $past(sel_q[K-2:0]));

  // R2: all columns off silences every output
  a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> (y == '0 && !par_and && !par_or));

  if (HEALTHY) begin : g_healthy
    // R10: one column under both forces gives odd parity on both outputs
    a_r10_single_parity: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(sel_q) && force_true && force_comp) |-> (par_and && par_or));
  end

endmodule

bind pla_testable pla_testable_chk #(
  .K       (K),
  .N_OUT   (N_OUT),
  .HEALTHY (HEALTHY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_shift  (sel_shift),
  .sel_in     (sel_in),
  .force_true (force_true),
  .force_comp (force_comp),
  .sel_q      (sel_q),
  .y          (y),
  .par_and    (par_and),
  .par_or     (par_or)
);

// File: tb/pla_testable_bench.sv
module pla_testable_bench;

  localparam int K = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_shift = 1'b0;
  logic       sel_in = 1'b0;
  logic       force_true = 1'b0;
  logic       force_comp = 1'b0;
  logic [3:0] data_in = '0;
  logic [1:0] y, y_bad;
  logic       par_and, par_or, pa_bad, po_bad;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  pla_testable u_pla_testable (
    .clk(clk), .rst_n(rst_n), .sel_shift(sel_shift), .sel_in(sel_in),
    .force_true(force_true), .force_comp(force_comp), .data_in(data_in),
    .y(y), .par_and(par_and), .par_or(par_or)
  );

  // Defective copy: term 2 (column 2) wrongly also drives y2.
  pla_testable #(.FLIP_OR(12'h080)) u_faulty (
    .clk(clk), .rst_n(rst_n), .sel_shift(sel_shift), .sel_in(sel_in),
    .force_true(force_true), .force_comp(force_comp), .data_in(data_in),
    .y(y_bad), .par_and(pa_bad), .par_or(po_bad)
  );

  // {data_in, force_true, force_comp, enables[7:1], y2 y1, par_and, par_or}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {4'b0000, 1'b1, 1'b1, 7'b0000001, 2'b11, 1'b1, 1'b1},  // R10 col1
    {4'b0000, 1'b1, 1'b1, 7'b0000010, 2'b01, 1'b1, 1'b1},  // R10 col2
    {4'b0000, 1'b1, 1'b1, 7'b0000100, 2'b01, 1'b1, 1'b1},  // R10 col3
    {4'b0000, 1'b1, 1'b1, 7'b0001000, 2'b10, 1'b1, 1'b1},  // R10 col4
    {4'b0000, 1'b1, 1'b1, 7'b0010000, 2'b10, 1'b1, 1'b1},  // R10 col5
    {4'b0000, 1'b1, 1'b1, 7'b0100000, 2'b10, 1'b1, 1'b1},  // R10 col6
    {4'b0000, 1'b1, 1'b1, 7'b1000000, 2'b00, 1'b1, 1'b1},  // R7 R8 parity col
    {4'b1111, 1'b1, 1'b0, 7'b1111111, 2'b11, 1'b0, 1'b1},  // R5
    {4'b0000, 1'b0, 1'b1, 7'b1111111, 2'b10, 1'b1, 1'b1},  // R6
    {4'b0101, 1'b0, 1'b0, 7'b1111111, 2'b00, 1'b0, 1'b0},  // R1
    {4'b1011, 1'b0, 1'b0, 7'b1111111, 2'b11, 1'b0, 1'b1},  // R1
    {4'b1011, 1'b0, 1'b0, 7'b1111110, 2'b10, 1'b1, 1'b1},  // R2
    {4'b0110, 1'b0, 1'b0, 7'b1111111, 2'b01, 1'b0, 1'b1}   // R1
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic load_sel(input logic [K-1:0] s);
    for (int i = K - 1; i >= 0; i--) begin
      @(negedge clk);
      sel_shift = 1'b1;
      sel_in    = s[i];
    end
    @(negedge clk);
    sel_shift = 1'b0;
  endtask

  // Normal-mode model from the R1 equations: returns {y2, y1, par_and, par_or}.
  function automatic logic [3:0] model(input logic [3:0] x);
    logic t0, t1, t2, t3, t4, t5, a, b;
    t0 = x[0] & x[1];
    t1 = ~x[0] & x[2];
    t2 = x[1] & ~x[3];
    t3 = x[2] & x[3];
    t4 = ~x[1] & ~x[2];
    t5 = x[0] & ~x[2] & x[3];
    a = t0 | t1 | t2;
    b = t0 | t3 | t4 | t5;
    return {b, a, t0 ^ t1 ^ t2 ^ t3 ^ t4 ^ t5, a ^ b ^ t0};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state seen at ports, all columns on under both forces
    force_true = 1'b1; force_comp = 1'b1;
    #1 check("R4 reset enables", {y, par_and, par_or}, 4'b1111);
    force_true = 1'b0; force_comp = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      load_sel(VEC[v][10:4]);
      data_in    = VEC[v][16:13];
      force_true = VEC[v][12];
      force_comp = VEC[v][11];
      #1 check($sformatf("R1/R2/R5-R10 vector %0d", v), {y, par_and, par_or}, VEC[v][3:0]);
    end

    // R1: all input values in normal mode
    load_sel('1);
    force_true = 1'b0; force_comp = 1'b0;
    for (int x = 0; x < 16; x++) begin
      data_in = 4'(x);
      #1 check($sformatf("R1 x=%0d", x), {y, par_and, par_or}, model(4'(x)));
      @(negedge clk);
    end

    // R9: same-cycle response, no clock edge in between
    data_in = 4'b0101;
    #0.5 data_in = 4'b1011;
    #0.5 check("R9 combinational", {y, par_and, par_or}, model(4'b1011));

    // R2: all columns off
    load_sel('0);
    force_true = 1'b1; force_comp = 1'b1;
    #1 check("R2 all off", {y, par_and, par_or}, 4'b0000);

    // R3: load only column 1, then hold while sel_in toggles
    load_sel(7'b0000001);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      sel_in = ~sel_in;
    end
    #1 check("R3 hold", {y, par_and, par_or}, 4'b1111);
    // R3: one shift moves the enable to column 2 (y1 only)
    @(negedge clk); sel_shift = 1'b1; sel_in = 1'b0;
    @(negedge clk); sel_shift = 1'b0;
    #1 check("R3 single shift", {y, par_and, par_or}, 4'b0111);

    // R8: injected OR defect on column 2 flips par_or in the faulty copy
    #1 check("R8 fault exposed", {y_bad, pa_bad, po_bad}, 4'b1110);

    // R4: asynchronous reset restores all-on
    rst_n = 1'b0;
    #1 check("R4 async reset", {y, par_and, par_or}, 4'b1111);
    @(negedge clk); rst_n = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule